// File: doc/BRIEF.md
# MSI Ring Buffer Capture Controller

This block sits behind the address decode that recognises message-signalled interrupt writes. Each message carries a 32-bit interrupt number. The block turns every accepted message into a 16-byte record and emits it as one memory write into a circular queue in system memory. The queue's location comes from a 64-bit base address that software programs as two 32-bit halves. Its size is selected by a 2-bit code and can be 32 KB, 64 KB, 128 KB or 256 KB.

The block keeps a producer offset and a consumer offset, both as byte offsets inside the queue. It raises its interrupt line while the two offsets differ. After software drains records, it moves the consumer offset forward through the register port. When the queue is full, one control bit decides what happens to the incoming message: it is either stalled at the input or dropped. A dropped message can optionally set a sticky flag. To quiesce the block before a reset, software clears the enable and interrupt-enable bits.

Top module: `msi_ring_capture`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, `msi_ready` is low and `mem_valid` is low.
- R2: The register port decodes these word addresses: 0 is control, 3 is base high, 4 is base low, 5 is the consumer offset and 6 is the producer offset. Reads take effect in the same cycle. Any other address reads zero.
- R3: Control bit 0 is the enable. `msi_ready` is high only while this bit is set and no record is waiting on the memory port. While the bit is clear, nothing is captured.
- R4: An accepted, non-dropped message presents `mem_addr` = {base high, base low} + producer offset. `mem_data[31:0]` carries the interrupt number, with byte 0 in bits 7:0, and `mem_data[127:32]` is zero. These values hold steady while `mem_valid` is high and `mem_ready` is low.
- R5: Each completed memory write (`mem_valid` and `mem_ready` both high) advances the producer offset by 16. The offset wraps to zero at the queue size, using the mask (size-1) with bits 3:0 cleared.
- R6: Writes to either offset register are ANDed with that same mask.
- R7: `irq` = enable (bit 0) AND interrupt enable (bit 3) AND (consumer offset != producer offset). Clearing either bit drops `irq` and, for bit 0, `msi_ready`.
- R8: The queue is full when (producer + 16) masked equals the consumer offset. While it is full and control bit 4 (stall-on-full) is set, `msi_ready` stays low.
- R9: While the queue is full and bit 4 is clear, a message is accepted and then dropped: no memory write is made and the producer offset does not move. If control bit 1 (report-full) is set, the drop also sets control bit 16. If bit 1 is clear, bit 16 stays zero.
- R10: Bit 16 is sticky. A control write with bit 16 set clears it.
- R11: Control bits 9:8 hold code c, which gives a queue size of 2^(15+c) bytes. Codes 0 to 3 wrap the producer offset after 0x7FF0, 0xFFF0, 0x1FFF0 and 0x3FFF0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msi_valid | input | 1 | Interrupt message present |
| msi_ready | output | 1 | Message accepted this cycle |
| msi_num | input | 32 | Interrupt number of the message |
| mem_valid | output | 1 | Record write pending |
| mem_ready | input | 1 | Memory accepts the record |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record, little-endian |
| irq | output | 1 | Unread records present |

## Verification
Several properties are checked on every cycle:
- the input handshake never accepts a message while a record is pending;
- a pending record stays stable until it is taken, and its padding is zero;
- the offsets stay 16-byte aligned;
- the interrupt and ready lines are silent when the block is disabled;
- stall-on-full blocks the input.

Other behaviours need the bench's scenarios, because each depends on a chosen history of register writes and traffic:
- the wrap point for each size code;
- masking of offset writes;
- the difference between stalling and dropping on a full queue;
- the sticky full flag and how it is cleared;
- the exact record addresses under random bases and memory back-pressure.

// File: rtl/msi_ring_capture.sv
module msi_ring_capture #(
  parameter int MIN_LOG = 15,
  parameter int REC_LOG = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         msi_valid,
  output logic         msi_ready,
  input  logic [31:0]  msi_num,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic [63:0]  mem_addr,
  output logic [127:0] mem_data,
  output logic         irq
);
  localparam int OFF_W = MIN_LOG + 3;
  localparam logic [OFF_W-1:0] STEP = OFF_W'(1) << REC_LOG;
  localparam logic [OFF_W-1:0] ALIGN = ~(STEP - OFF_W'(1));

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_BHI  = 3'd3;
  localparam logic [2:0] A_BLO  = 3'd4;
  localparam logic [2:0] A_ROFF = 3'd5;
  localparam logic [2:0] A_WOFF = 3'd6;

  logic             en, full_rep, ien, full_stop, full_flag;
  logic [1:0]       size_code;
  logic [31:0]      base_hi, base_lo;
  logic [OFF_W-1:0] roff, woff;
  logic [OFF_W-1:0] size_mask, woff_next;
  logic             full, accept;
  logic [31:0]      ctrl_rd;

  assign size_mask = ((OFF_W'(1) << (MIN_LOG + int'(size_code))) - OFF_W'(1)) & ALIGN;
  assign woff_next = (woff + STEP) & size_mask;
  assign full      = (woff_next == roff);
  assign msi_ready = en & ~mem_valid & ~(full & full_stop);
  assign accept    = msi_valid & msi_ready;
  assign mem_addr  = {base_hi, base_lo} + 64'(woff);
  assign irq       = en & ien & (roff != woff);

  assign ctrl_rd = {15'd0, full_flag, 6'd0, size_code, 3'd0, full_stop, ien, 1'b0, full_rep, en};

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_rd;
      A_BHI:   reg_rdata = base_hi;
      A_BLO:   reg_rdata = base_lo;
      A_ROFF:  reg_rdata = 32'(roff);
      A_WOFF:  reg_rdata = 32'(woff);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      full_rep  <= 1'b0;
      ien       <= 1'b0;
      full_stop <= 1'b0;
      full_flag <= 1'b0;
      size_code <= 2'd0;
      base_hi   <= 32'd0;
      base_lo   <= 32'd0;
      roff      <= '0;
      woff      <= '0;
      mem_valid <= 1'b0;
      mem_data  <= '0;
    end else begin
      if (mem_valid && mem_ready) begin
        mem_valid <= 1'b0;
        woff      <= woff_next;
      end
      if (accept && !full) begin
        mem_valid <= 1'b1;
        mem_data  <= {96'd0, msi_num};
      end
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin
            en        <= reg_wdata[0];
            full_rep  <= reg_wdata[1];
            ien       <= reg_wdata[3];
            full_stop <= reg_wdata[4];
            size_code <= reg_wdata[9:8];
            if (reg_wdata[16]) full_flag <= 1'b0;
          end
          A_BHI:  base_hi <= reg_wdata;
          A_BLO:  base_lo <= reg_wdata;
          A_ROFF: roff    <= reg_wdata[OFF_W-1:0] & size_mask;
          A_WOFF: woff    <= reg_wdata[OFF_W-1:0] & size_mask;
          default: ;
        endcase
      end
      if (accept && full && full_rep) full_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/msi_ring_capture_chk.sv
module msi_ring_capture_chk #(
  parameter int OFF_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msi_ready,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [63:0]      mem_addr,
  input logic [127:0]     mem_data,
  input logic             irq,
  input logic             en,
  input logic             ien,
  input logic             full_stop,
  input logic [1:0]       size_code,
  input logic [OFF_W-1:0] roff,
  input logic [OFF_W-1:0] woff
);
  logic [31:0] qsize, wnext;
  assign qsize = 32'd1 << (15 + int'(size_code));
  assign wnext = (32'(woff) + 32'd16) % qsize;

  p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_ready |-> (!mem_valid && en));

  p_hold_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_data[127:32] == 96'd0));

  p_offset_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (woff[3:0] == 4'd0) && (roff[3:0] == 4'd0));

  p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && ien) |-> !irq);

  p_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_stop && (wnext == 32'(roff))) |-> !msi_ready);
endmodule

bind msi_ring_capture msi_ring_capture_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_ready(msi_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
  .en(en), .ien(ien), .full_stop(full_stop), .size_code(size_code),
  .roff(roff), .woff(woff)
);

// File: tb/msi_ring_capture_bench.sv
module msi_ring_capture_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic         msi_valid = 1'b0;
  logic         msi_ready;
  logic [31:0]  msi_num = 32'd0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  msi_ring_capture u_msi_ring_capture (.*);

  function automatic logic [31:0] f_mask(input int code);
    return ((32'd1 << (15 + code)) - 32'd1) & ~32'hF;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] num, input int max_cyc, output bit acc);
    bit r;
    acc = 1'b0;
    @(negedge clk);
    msi_valid = 1'b1; msi_num = num;
    for (int k = 0; k < max_cyc; k++) begin
      #1 r = msi_ready;
      @(posedge clk);
      if (r) begin acc = 1'b1; break; end
      @(negedge clk);
    end
    #1 msi_valid = 1'b0;
  endtask

  task automatic take(input string tag, input logic [63:0] ea, input logic [31:0] num, input int dly);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (mem_valid) break;
    end
    chk({tag, " mem_valid"}, 128'(mem_valid), 128'd1);
    chk({tag, " mem_addr"}, 128'(mem_addr), 128'(ea));
    chk({tag, " mem_data"}, mem_data, {96'd0, num});
    repeat (dly) @(negedge clk);
    chk({tag, " hold"}, {mem_addr, 64'(mem_data[31:0])}, {ea, 32'd0, num});
    mem_ready = 1'b1;
    @(posedge clk); #1;
    mem_ready = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, num, m, bhi, blo, ew, er;
    bit acc;
    void'($urandom(32'd7531));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); chk("R1 ctrl", 128'(d), 128'd0);
    rd(3'd6, d); chk("R1 woff", 128'(d), 128'd0);
    chk("R1 outputs", {125'd0, irq, msi_ready, mem_valid}, 128'd0);

    // R3 disabled: nothing captured
    send(32'hDEAD, 3, acc);
    chk("R3 disabled accept", 128'(acc), 128'd0);
    chk("R3 disabled mem", 128'(mem_valid), 128'd0);

    // R2 register map
    wr(3'd3, 32'h0000_0012);
    wr(3'd4, 32'h8000_0000);
    rd(3'd3, d); chk("R2 base hi", 128'(d), 128'h12);
    rd(3'd4, d); chk("R2 base lo", 128'(d), 128'h8000_0000);
    rd(3'd1, d); chk("R2 unmapped", 128'(d), 128'd0);
    wr(3'd0, 32'h109);
    rd(3'd0, d); chk("R2 ctrl", 128'(d), 128'h109);

    // R4/R5/R7 first record
    send(32'h1122_3344, 4, acc);
    chk("R3 enabled accept", 128'(acc), 128'd1);
    take("R4 first", 64'h12_8000_0000, 32'h1122_3344, 2);
    rd(3'd6, d); chk("R5 advance", 128'(d), 128'h10);
    chk("R7 irq on", 128'(irq), 128'd1);
    wr(3'd5, 32'h10);
    chk("R7 irq off", 128'(irq), 128'd0);

    // R6 masked offset writes
    wr(3'd5, 32'h0001_FFFF);
    rd(3'd5, d); chk("R6 roff mask", 128'(d), 128'hFFF0);
    wr(3'd5, 32'h10);

    // R5/R11 wrap for each size code
    for (int c = 0; c < 4; c++) begin
      m = f_mask(c);
      wr(3'd0, 32'h9 | (32'(c) << 8));
      wr(3'd5, 32'h20);
      wr(3'd6, m);
      send(32'(c + 5), 4, acc);
      take("R11 wrap rec", 64'h12_8000_0000 + 64'(m), 32'(c + 5), 0);
      rd(3'd6, d); chk($sformatf("R11 wrap code %0d", c), 128'(d), 128'd0);
    end

    // R8 stall when full
    wr(3'd0, 32'h19);
    wr(3'd5, 32'h100);
    wr(3'd6, 32'hF0);
    send(32'hAA, 3, acc);
    chk("R8 stall", 128'(acc), 128'd0);
    wr(3'd5, 32'h200);
    send(32'hAB, 3, acc);
    chk("R8 release", 128'(acc), 128'd1);
    take("R8 after", 64'h12_8000_00F0, 32'hAB, 1);

    // R9 drop without reporting
    wr(3'd0, 32'h09);
    wr(3'd5, 32'h100);
    wr(3'd6, 32'hF0);
    send(32'hBB, 3, acc);
    chk("R9 drop accept", 128'(acc), 128'd1);
    repeat (3) @(negedge clk);
    chk("R9 no write", 128'(mem_valid), 128'd0);
    rd(3'd6, d); chk("R9 woff kept", 128'(d), 128'hF0);
    rd(3'd0, d); chk("R9 no flag", 128'(d[16]), 128'd0);

    // R9 drop with reporting, R10 clear
    wr(3'd0, 32'h0B);
    send(32'hCC, 3, acc);
    rd(3'd0, d); chk("R9 flag set", 128'(d), 128'h1000B);
    wr(3'd0, 32'h1000B);
    rd(3'd0, d); chk("R10 flag clear", 128'(d), 128'h0B);

    // R4/R5 random traffic, size code 2
    bhi = $urandom; blo = $urandom & ~32'hF;
    wr(3'd3, bhi); wr(3'd4, blo);
    wr(3'd0, 32'h209);
    m = f_mask(2);
    ew = ($urandom & m);
    wr(3'd6, ew);
    for (int i = 0; i < 24; i++) begin
      er = (ew - 32'h800) & m;
      wr(3'd5, er);
      num = $urandom;
      send(num, 4, acc);
      take("R4 random", {bhi, blo} + 64'(ew), num, int'($urandom % 4));
      ew = (ew + 32'h10) & m;
      rd(3'd6, d); chk("R5 random woff", 128'(d), 128'(ew));
    end

    // R7 disable drops irq and ready
    chk("R7 irq pending", 128'(irq), 128'd1);
    wr(3'd0, 32'h208);
    chk("R7 disabled", {126'd0, irq, msi_ready}, 128'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule